// File: doc/BRIEF.md
# Pin Event Detector

This block watches a bank of asynchronous pin inputs. It brings each one into the clock domain and, for each pin, looks for a condition chosen by that pin's 4-bit trigger code. The condition can be a rising edge, a falling edge, either edge, a low level or a high level. When the condition occurs, the block sets the pin's bit in a status word. From those flags it produces one interrupt line and one DMA request line. The trigger codes also provide per-pin trigger outputs that follow the synchronized level.

Software sets up the pins through a small register port. It can write one pin's code, or write one code to any subset of the lower or upper half of the pins. It reads the flags back and clears them by writing ones. A DMA controller pulses a done input after each transfer; this clears the flags that belong to pins in DMA-request codes.

Top module: `pin_evt_ctrl`

## Requirements
- R1: After reset, every flag, every pin code, `irq_out`, `dma_req_out` and `trig_out` is zero.
- R2: A write to address i (0 to 31) stores `reg_wdata[3:0]` as pin i's code. A read of address i returns that code in bits [3:0], with zeros above.
- R3: A write to address 33 (pins 0–15) or 34 (pins 16–31) gives every pin whose bit in `reg_wdata[15:0]` is set the code in `reg_wdata[19:16]`. Pins whose mask bit is clear keep their code. Bits [31:20] are ignored.
- R4: Edge codes set the pin's flag on a rising edge (1, 5, 9), a falling edge (2, 6, 10) or either edge (3, 7, 11). The flag is visible after the second clock edge that follows the first clock edge seeing the new pin value.
- R5: Code 8 sets the flag while the synchronized pin is low, and code 12 while it is high. If the level is still present when the flag is cleared, the flag is set again on the next cycle.
- R6: Address 32 reads the flag word, with bit i for pin i. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R7: A `dma_done` pulse clears the flags of pins whose code is 1, 2 or 3. It leaves all other flags unchanged.
- R8: `irq_out` is high when any pin with code 8–12 has its flag set. `dma_req_out` is high when any pin with code 1–3 has its flag set. Flags of pins with codes 5–7 drive neither output.
- R9: With code 13, `trig_out[i]` equals the synchronized pin level. With code 14, it equals the inverted level. With any other code it is 0, and codes 13 and 14 never set a flag.
- R10: If a clear (by write or by `dma_done`) and a new event hit the same pin in the same cycle, the flag stays set.
- R11: Codes 0, 4 and 15 never set a flag and never drive a trigger output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Asynchronous pin levels |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| dma_done | input | 1 | DMA transfer completed pulse |
| irq_out | output | 1 | Combined interrupt request |
| dma_req_out | output | 1 | Combined DMA request |
| trig_out | output | 32 | Per-pin trigger outputs |

## Verification
Several rules are checked by the assertions on every cycle:
- every detected event lands in the flag bank the next cycle, even against a clear;
- no flag appears without an event;
- write-one clears and done pulses remove the targeted flags unless an event hit them;
- the request lines are never high with an empty flag word.

The bench covers the rest. It checks the exact decode of all sixteen codes on the lowest and highest pin, the two-edge synchronizer latency and the masked global code writes. It also shows the observable difference between a level code and an edge code after a clear.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int MODE_W = 4;
  localparam int DATA_W = 32;
  localparam int GMODE_LSB = 16;

  typedef enum logic [MODE_W-1:0] {
    TM_OFF       = 4'h0,
    TM_DMA_RISE  = 4'h1,
    TM_DMA_FALL  = 4'h2,
    TM_DMA_BOTH  = 4'h3,
    TM_RSVD_4    = 4'h4,
    TM_FLG_RISE  = 4'h5,
    TM_FLG_FALL  = 4'h6,
    TM_FLG_BOTH  = 4'h7,
    TM_IRQ_LOW   = 4'h8,
    TM_IRQ_RISE  = 4'h9,
    TM_IRQ_FALL  = 4'hA,
    TM_IRQ_BOTH  = 4'hB,
    TM_IRQ_HIGH  = 4'hC,
    TM_TRIG_HI   = 4'hD,
    TM_TRIG_LO   = 4'hE,
    TM_RSVD_F    = 4'hF
  } trig_mode_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
    logic is_dma;
    logic is_irq;
    logic trig_hi;
    logic trig_lo;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] code);
    mode_dec_t d;
    d = '0;
    case (trig_mode_e'(code))
      TM_DMA_RISE: begin d.on_rise = 1'b1; d.is_dma = 1'b1; end
      TM_DMA_FALL: begin d.on_fall = 1'b1; d.is_dma = 1'b1; end
      TM_DMA_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_dma = 1'b1; end
      TM_FLG_RISE: d.on_rise = 1'b1;
      TM_FLG_FALL: d.on_fall = 1'b1;
      TM_FLG_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; end
      TM_IRQ_LOW:  begin d.on_low = 1'b1; d.is_irq = 1'b1; end
      TM_IRQ_RISE: begin d.on_rise = 1'b1; d.is_irq = 1'b1; end
      TM_IRQ_FALL: begin d.on_fall = 1'b1; d.is_irq = 1'b1; end
      TM_IRQ_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_irq = 1'b1; end
      TM_IRQ_HIGH: begin d.on_high = 1'b1; d.is_irq = 1'b1; end
      TM_TRIG_HI:  d.trig_hi = 1'b1;
      TM_TRIG_LO:  d.trig_lo = 1'b1;
      default:     d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] meta_d;
  logic [WIDTH-1:0] stable_q;
  logic [WIDTH-1:0] stable_d;

  always_comb begin
    meta_d   = async_in;
    stable_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= meta_d;
      stable_q <= stable_d;
    end
  end

  assign sync_out = stable_q;

endmodule

// File: rtl/pin_mode_bank.sv
module pin_mode_bank
  import pin_evt_pkg::*;
#(
  parameter int HALF_PINS = 16,
  parameter int NUM_PINS  = 2 * HALF_PINS,
  parameter int ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] GCFG_LO_ADDR = ADDR_W'(NUM_PINS + 1),
  parameter logic [ADDR_W-1:0] GCFG_HI_ADDR = ADDR_W'(NUM_PINS + 2)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_PINS-1:0][MODE_W-1:0]  modes
);

  logic lo_hit;
  logic hi_hit;
  logic [MODE_W-1:0] gcode;
  logic unused_wdata_hi;

  assign lo_hit = wr_en && (addr == GCFG_LO_ADDR);
  assign hi_hit = wr_en && (addr == GCFG_HI_ADDR);
  assign gcode  = wdata[GMODE_LSB +: MODE_W];
  assign unused_wdata_hi = ^wdata[DATA_W-1:GMODE_LSB+MODE_W];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic              own_hit;
    logic              grp_hit;
    logic              mode_en;
    logic [MODE_W-1:0] mode_d;
    logic [MODE_W-1:0] mode_q;

    assign own_hit = wr_en && (addr == ADDR_W'(i));

    if (i < HALF_PINS) begin : g_lo
      assign grp_hit = lo_hit && wdata[i];
    end else begin : g_hi
      assign grp_hit = hi_hit && wdata[i-HALF_PINS];
    end

    always_comb begin
      mode_en = own_hit || grp_hit;
      mode_d  = mode_q;
      if (own_hit)      mode_d = wdata[MODE_W-1:0];
      else if (grp_hit) mode_d = gcode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_en) mode_q <= mode_d;
    end

    assign modes[i] = mode_q;
  end

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PINS-1:0]             lvl,
  input  logic [NUM_PINS-1:0][MODE_W-1:0] modes,
  output logic [NUM_PINS-1:0]             evt,
  output logic [NUM_PINS-1:0]             dma_sel,
  output logic [NUM_PINS-1:0]             irq_sel,
  output logic [NUM_PINS-1:0]             trig
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] prev_d;

  assign prev_d = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_det
    mode_dec_t dec;
    logic      rise;
    logic      fall;

    assign dec  = decode_mode(modes[i]);
    assign rise = lvl[i] & ~prev_q[i];
    assign fall = ~lvl[i] & prev_q[i];

    assign evt[i]     = (dec.on_rise & rise) | (dec.on_fall & fall) |
                        (dec.on_low & ~lvl[i]) | (dec.on_high & lvl[i]);
    assign dma_sel[i] = dec.is_dma;
    assign irq_sel[i] = dec.is_irq;
    assign trig[i]    = (dec.trig_hi & lvl[i]) | (dec.trig_lo & ~lvl[i]);
  end

endmodule

// File: rtl/pin_flag_bank.sv
module pin_flag_bank #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt,
  input  logic [NUM_PINS-1:0] sw_clr,
  input  logic [NUM_PINS-1:0] dma_sel,
  input  logic                dma_done,
  output logic [NUM_PINS-1:0] flags
);

  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] flag_d;
  logic [NUM_PINS-1:0] clr_all;

  always_comb begin
    clr_all = sw_clr | ({NUM_PINS{dma_done}} & dma_sel);
    // a fresh event wins over any clear in the same cycle
    flag_d  = (flag_q & ~clr_all) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;

endmodule

// File: rtl/pin_evt_ctrl.sv
module pin_evt_ctrl
  import pin_evt_pkg::*;
#(
  parameter int HALF_PINS = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [2*HALF_PINS-1:0]             pin_in,
  input  logic                               reg_wr_en,
  input  logic [$clog2(2*HALF_PINS+3)-1:0]   reg_addr,
  input  logic [31:0]                        reg_wdata,
  output logic [31:0]                        reg_rdata,
  input  logic                               dma_done,
  output logic                               irq_out,
  output logic                               dma_req_out,
  output logic [2*HALF_PINS-1:0]             trig_out
);

  localparam int NUM_PINS  = 2 * HALF_PINS;
  localparam int ADDR_W    = $clog2(NUM_PINS + 3);
  localparam int PIN_IDX_W = $clog2(NUM_PINS);
  localparam logic [ADDR_W-1:0] STATUS_ADDR  = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] GCFG_LO_ADDR = ADDR_W'(NUM_PINS + 1);
  localparam logic [ADDR_W-1:0] GCFG_HI_ADDR = ADDR_W'(NUM_PINS + 2);

  logic [NUM_PINS-1:0]             lvl_w;
  logic [NUM_PINS-1:0][MODE_W-1:0] modes_w;
  logic [NUM_PINS-1:0]             evt_w;
  logic [NUM_PINS-1:0]             dma_sel_w;
  logic [NUM_PINS-1:0]             irq_sel_w;
  logic [NUM_PINS-1:0]             sw_clr_w;
  logic [NUM_PINS-1:0]             flag_w;

  pin_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (lvl_w)
  );

  pin_mode_bank #(
    .HALF_PINS    (HALF_PINS),
    .NUM_PINS     (NUM_PINS),
    .ADDR_W       (ADDR_W),
    .GCFG_LO_ADDR (GCFG_LO_ADDR),
    .GCFG_HI_ADDR (GCFG_HI_ADDR)
  ) u_modes (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .modes (modes_w)
  );

  pin_event_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl_w),
    .modes   (modes_w),
    .evt     (evt_w),
    .dma_sel (dma_sel_w),
    .irq_sel (irq_sel_w),
    .trig    (trig_out)
  );

  assign sw_clr_w = (reg_wr_en && (reg_addr == STATUS_ADDR)) ?
                    reg_wdata[NUM_PINS-1:0] : '0;

  pin_flag_bank #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_w),
    .sw_clr   (sw_clr_w),
    .dma_sel  (dma_sel_w),
    .dma_done (dma_done),
    .flags    (flag_w)
  );

  assign irq_out     = |(flag_w & irq_sel_w);
  assign dma_req_out = |(flag_w & dma_sel_w);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < STATUS_ADDR) begin
      reg_rdata[MODE_W-1:0] = modes_w[reg_addr[PIN_IDX_W-1:0]];
    end else if (reg_addr == STATUS_ADDR) begin
      reg_rdata[NUM_PINS-1:0] = flag_w;
    end
  end

endmodule

// File: rtl/pin_evt_ctrl_sva.sv
module pin_evt_ctrl_sva #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [31:0]         reg_wdata,
  input logic                dma_done,
  input logic                irq_out,
  input logic                dma_req_out,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] dma_sel,
  input logic [NUM_PINS-1:0] flags
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_PINS);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (flags == '0 && !irq_out && !dma_req_out);
    end
  end

  p_event_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt) & ~flags) == '0));

  p_no_flag_without_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(evt)) == '0));

  p_write_one_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr_en) && $past(reg_addr) == STATUS_ADDR) |->
    ((flags & $past(reg_wdata[NUM_PINS-1:0]) & ~$past(evt)) == '0));

  p_dma_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_done) |-> ((flags & $past(dma_sel) & ~$past(evt)) == '0));

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (flags != '0));

  p_dma_req_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_out |-> (flags != '0));

endmodule

bind pin_evt_ctrl pin_evt_ctrl_sva #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .dma_done    (dma_done),
  .irq_out     (irq_out),
  .dma_req_out (dma_req_out),
  .evt         (evt_w),
  .dma_sel     (dma_sel_w),
  .flags       (flag_w)
);

// File: tb/tb_pin_evt_ctrl.sv
module tb_pin_evt_ctrl;

  localparam int NP = 32;
  localparam logic [5:0] A_STAT = 6'd32;
  localparam logic [5:0] A_GLO  = 6'd33;
  localparam logic [5:0] A_GHI  = 6'd34;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] pin_in;
  logic          reg_wr_en;
  logic [5:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          dma_done;
  logic          irq_out;
  logic          dma_req_out;
  logic [NP-1:0] trig_out;

  int n_checks;
  int n_fail;

  pin_evt_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .dma_done    (dma_done),
    .irq_out     (irq_out),
    .dma_req_out (dma_req_out),
    .trig_out    (trig_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit is_rise(input int m);
    return (m == 1 || m == 3 || m == 5 || m == 7 || m == 9 || m == 11);
  endfunction
  function automatic bit is_fall(input int m);
    return (m == 2 || m == 3 || m == 6 || m == 7 || m == 10 || m == 11);
  endfunction
  function automatic bit is_dma(input int m);
    return (m >= 1 && m <= 3);
  endfunction
  function automatic bit is_irq(input int m);
    return (m >= 8 && m <= 12);
  endfunction

  task automatic check_pin(input int p, input int m, input bit exp_flag,
                           input bit lvl, input string step);
    logic [31:0] st;
    bit exp_trig;
    rd(A_STAT, st);
    exp_trig = (m == 13) ? lvl : ((m == 14) ? ~lvl : 1'b0);
    check({31'd0, st[p]}, {31'd0, exp_flag},
          $sformatf("R4/R5/R11 flag pin%0d code%0d %s", p, m, step));
    check({31'd0, irq_out}, {31'd0, exp_flag & is_irq(m)},
          $sformatf("R8 irq pin%0d code%0d %s", p, m, step));
    check({31'd0, dma_req_out}, {31'd0, exp_flag & is_dma(m)},
          $sformatf("R8 dma_req pin%0d code%0d %s", p, m, step));
    check(trig_out, exp_trig ? (32'd1 << p) : 32'd0,
          $sformatf("R9 trig pin%0d code%0d %s", p, m, step));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rv;
    bit f;
    n_checks  = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    pin_in    = '0;
    reg_wr_en = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    dma_done  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle(1);

    // R1 reset state
    rd(6'd0, rv);   check(rv, 32'd0, "R1 pin0 code after reset");
    rd(6'd31, rv);  check(rv, 32'd0, "R1 pin31 code after reset");
    rd(A_STAT, rv); check(rv, 32'd0, "R1 flags after reset");
    check({31'd0, irq_out}, 32'd0, "R1 irq after reset");
    check({31'd0, dma_req_out}, 32'd0, "R1 dma_req after reset");
    check(trig_out, 32'd0, "R1 trig after reset");

    // Sweep of all codes on the lowest and highest pin
    for (int k = 0; k < 2; k++) begin
      int p;
      p = (k == 0) ? 0 : 31;
      for (int m = 0; m < 16; m++) begin
        pin_in = '0;
        wr(6'(p), 32'(m));
        rd(6'(p), rv);
        check(rv, 32'(m), $sformatf("R2 readback pin%0d", p));
        wr(A_STAT, 32'hFFFF_FFFF);
        settle(3);
        check_pin(p, m, (m == 8), 1'b0, "low");
        wr(A_STAT, 32'hFFFF_FFFF);
        pin_in[p] = 1'b1;
        settle(4);
        check_pin(p, m, is_rise(m) || m == 8 || m == 12, 1'b1, "rise");
        wr(A_STAT, 32'hFFFF_FFFF);
        settle(2);
        check_pin(p, m, (m == 12), 1'b1, "high after clear");
        pin_in[p] = 1'b0;
        settle(4);
        f = is_fall(m) || m == 8 || m == 12;
        check_pin(p, m, f, 1'b0, "fall");
        @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
        check_pin(p, m, f && !is_dma(m), 1'b0, "R7 after dma_done");
        wr(6'(p), 32'd0);
        wr(A_STAT, 32'hFFFF_FFFF);
        settle(1);
      end
    end

    // R6 partial write-one clear, zero writes ignored
    wr(6'd0, 32'h5);
    wr(6'd1, 32'h5);
    pin_in[1:0] = 2'b11;
    settle(4);
    rd(A_STAT, rv); check(rv, 32'h3, "R6 two flags set");
    wr(A_STAT, 32'h1);
    rd(A_STAT, rv); check(rv, 32'h2, "R6 only pin0 cleared");
    wr(A_STAT, 32'h0);
    rd(A_STAT, rv); check(rv, 32'h2, "R6 zero write no effect");
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, rv); check(rv, 32'h0, "R6 all cleared");
    check({31'd0, irq_out}, 32'd0, "R8 code5 no irq");
    wr(6'd0, 32'h0);
    wr(6'd1, 32'h0);
    pin_in = '0;
    settle(3);

    // R10 clear collides with a level event
    wr(6'd5, 32'hC);
    pin_in[5] = 1'b1;
    settle(4);
    wr(A_STAT, 32'h20);
    rd(A_STAT, rv); check(rv, 32'h20, "R10 clear and event same cycle keeps flag");
    check({31'd0, irq_out}, 32'd1, "R5 level irq persists");
    wr(6'd5, 32'h0);
    pin_in = '0;
    settle(3);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R3 masked global code writes
    wr(A_GLO, 32'hFFF9_A5A5);
    for (int i = 0; i < 32; i++) begin
      rd(6'(i), rv);
      check(rv, (i < 16 && ((32'hA5A5 >> i) & 1) == 1) ? 32'h9 : 32'h0,
            $sformatf("R3 low group pin%0d", i));
    end
    wr(A_GHI, 32'h000B_0003);
    rd(6'd16, rv); check(rv, 32'hB, "R3 high group pin16");
    rd(6'd17, rv); check(rv, 32'hB, "R3 high group pin17");
    rd(6'd18, rv); check(rv, 32'h0, "R3 high group pin18 unchanged");
    rd(6'd0, rv);  check(rv, 32'h9, "R3 low group untouched by high write");
    pin_in[17] = 1'b1;
    settle(4);
    rd(A_STAT, rv); check(rv, 32'h0002_0000, "R3 global code active pin17");
    check({31'd0, irq_out}, 32'd1, "R8 irq from code B");

    summary();
    $finish;
  end

endmodule